// File: doc/BRIEF.md
# FIFO Port Width Adapter with Selectable Half-Word Order

This block sits between the two external ports of a word-based FIFO and its 18-bit storage. On the write side it accepts either full 18-bit items or narrow 9-bit items. In narrow mode it joins two consecutive items into one storage word. On the read side it delivers either whole storage words or, in narrow mode, each word as two 9-bit items in turn. The storage core itself, its flags and any threshold programming are outside the block.

Each port's width and the half-word order are taken from three configuration pins while master reset is held. They stay fixed until the next master reset, so every mix of input and output width works. Partial reset drops any half-assembled or half-delivered word and keeps the latched configuration. All four data interfaces are valid/ready streams. A transfer happens in a cycle where both valid and ready are high. A source holds its valid and data steady until the transfer takes place. In wide mode the adapter passes valid forward and ready backward with no added cycle. In narrow mode it stalls one side only where a word boundary requires it.

Top module: `fifo_width_adapter`

## Requirements
- R1: While `mrst_n` is low, `cfg_wr_narrow` is sampled: 0 gives an 18-bit write port (each input transfer is one storage word, ready taken from `st_wready`); 1 gives a 9-bit write port.
- R2: While `mrst_n` is low, `cfg_rd_narrow` is sampled independently: 0 gives an 18-bit read port (each storage word is one output transfer); 1 gives a 9-bit read port.
- R3: While `mrst_n` is low, `cfg_little` is sampled. With 0 (big-endian), the first 9-bit item of a pair maps to storage bits 17:9 and the second to bits 8:0. With 1 (little-endian), the first item maps to bits 8:0 and the second to bits 17:9. This applies to both ports.
- R4: On a 9-bit write port only `in_data[8:0]` is used; bits 17:9 have no effect on stored words.
- R5: On a 9-bit read port the item appears on `out_data[8:0]` and `out_data[17:9]` is driven to zero.
- R6: Changes on the three configuration pins while `mrst_n` is high have no effect.
- R7: On a 9-bit write port the first item of a pair is always accepted (`in_ready`=1) and raises no `st_wvalid`. The second item raises `st_wvalid` with the joined word, and `in_ready` then equals `st_wready`.
- R8: On a 9-bit read port `st_rready` is high only while the second half of the current word is offered and `out_ready` is high. The storage word is therefore popped only after both halves have been taken.
- R9: A low `prst_n` for one cycle clears the held first write item and returns the read side to the first half, and keeps all latched configuration.
- R10: Back-pressure: `out_valid` follows `st_rvalid`, and in wide write mode `st_wvalid` follows `in_valid`. No transfer is lost or repeated while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous; samples configuration |
| prst_n | input | 1 | Partial reset, active low, synchronous; keeps configuration |
| cfg_wr_narrow | input | 1 | Write width select: 0 = 18-bit, 1 = 9-bit |
| cfg_rd_narrow | input | 1 | Read width select: 0 = 18-bit, 1 = 9-bit |
| cfg_little | input | 1 | Half-word order: 0 = big-endian, 1 = little-endian |
| in_valid | input | 1 | Write stream valid |
| in_ready | output | 1 | Write stream ready |
| in_data | input | 18 | Write stream data |
| st_wvalid | output | 1 | Storage write valid |
| st_wready | input | 1 | Storage write ready (space available) |
| st_wdata | output | 18 | Storage write word |
| st_rvalid | input | 1 | Storage read valid (word available) |
| st_rready | output | 1 | Storage read pop |
| st_rdata | input | 18 | Storage read word |
| out_valid | output | 1 | Read stream valid |
| out_ready | input | 1 | Read stream ready |
| out_data | output | 18 | Read stream data |

## Verification
Two things can happen in the same cycle. The second narrow write item can arrive while storage withholds ready. The half-item must then remain held and the commit must wait. On the read side, acceptance of the second half coincides with the storage pop. The bench drives all four valid and ready signals independently from a seeded random source, so these collisions arise often under every one of the eight configurations. Each cycle it compares the handshakes and data against a model of its own that tracks the pairing state and word order. Directed sequences then place a partial reset between the two halves on each side.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

  typedef struct packed {
    logic wr_narrow;
    logic rd_narrow;
    logic little;
  } fwa_cfg_t;

endpackage

// File: rtl/fwa_cfg_latch.sv
module fwa_cfg_latch
  import fwa_pkg::*;
(
  input  logic     clk,
  input  logic     mrst_n,
  input  fwa_cfg_t cfg_pins,
  output fwa_cfg_t cfg_q
);

  // Sampled on every edge while master reset is held, frozen afterwards.
  always_ff @(posedge clk) begin
    if (!mrst_n) cfg_q <= cfg_pins;
  end

  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!mrst_n)
    $past(mrst_n) |-> $stable(cfg_q));

endmodule

// File: rtl/fwa_packer.sv
module fwa_packer #(
  parameter int HALF_W = 9,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              narrow,
  input  logic              little,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FULL_W-1:0] in_data,
  output logic              wvalid,
  input  logic              wready,
  output logic [FULL_W-1:0] wdata
);

  logic              half_q;
  logic [HALF_W-1:0] held_q;
  logic              take;

  always_comb begin
    if (!narrow) begin
      wvalid   = in_valid;
      in_ready = wready;
      wdata    = in_data;
    end else begin
      wvalid   = in_valid && half_q;
      in_ready = half_q ? wready : 1'b1;
      wdata    = little ? {in_data[HALF_W-1:0], held_q}
                        : {held_q, in_data[HALF_W-1:0]};
    end
  end

  assign take = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) begin
      half_q <= 1'b0;
      held_q <= '0;
    end else if (narrow && take) begin
      if (!half_q) held_q <= in_data[HALF_W-1:0];
      half_q <= !half_q;
    end
  end

  p_half_only_narrow_r1: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    !narrow |-> !half_q);

  p_held_kept_r7: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (half_q && !take) |=> (half_q && $stable(held_q)));

  p_half_after_take_r7: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    $rose(half_q) |-> $past(take));

endmodule

// File: rtl/fwa_unpacker.sv
module fwa_unpacker #(
  parameter int HALF_W = 9,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              narrow,
  input  logic              little,
  input  logic              rvalid,
  output logic              rready,
  input  logic [FULL_W-1:0] rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FULL_W-1:0] out_data
);

  logic              phase_q;
  logic [HALF_W-1:0] half_sel;

  // phase 0 offers the first item of the word; endian picks which half is first
  assign half_sel = (phase_q ^ little) ? rdata[HALF_W-1:0] : rdata[FULL_W-1:HALF_W];

  always_comb begin
    out_valid = rvalid;
    if (!narrow) begin
      rready   = out_ready;
      out_data = rdata;
    end else begin
      rready   = out_ready && phase_q;
      out_data = {{HALF_W{1'b0}}, half_sel};
    end
  end

  always_ff @(posedge clk) begin
    if (!mrst_n || !prst_n) phase_q <= 1'b0;
    else if (narrow && out_valid && out_ready) phase_q <= !phase_q;
  end

  p_pop_resets_phase_r8: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (narrow && rvalid && rready) |=> !phase_q);

  p_phase_waits_r8: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    (phase_q && !(out_valid && out_ready)) |=> phase_q);

  p_upper_zero_r5: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
    narrow |-> (out_data[FULL_W-1:HALF_W] == '0));

endmodule

// File: rtl/fifo_width_adapter.sv
module fifo_width_adapter
  import fwa_pkg::*;
#(
  parameter int HALF_W = 9,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              cfg_wr_narrow,
  input  logic              cfg_rd_narrow,
  input  logic              cfg_little,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FULL_W-1:0] in_data,
  output logic              st_wvalid,
  input  logic              st_wready,
  output logic [FULL_W-1:0] st_wdata,
  input  logic              st_rvalid,
  output logic              st_rready,
  input  logic [FULL_W-1:0] st_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [FULL_W-1:0] out_data
);

  fwa_cfg_t cfg_pins;
  fwa_cfg_t cfg_q;

  assign cfg_pins = '{wr_narrow: cfg_wr_narrow, rd_narrow: cfg_rd_narrow, little: cfg_little};

  fwa_cfg_latch u_cfg (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .cfg_pins (cfg_pins),
    .cfg_q    (cfg_q)
  );

  fwa_packer #(.HALF_W(HALF_W)) u_pack (
    .clk      (clk),
    .mrst_n   (mrst_n),
    .prst_n   (prst_n),
    .narrow   (cfg_q.wr_narrow),
    .little   (cfg_q.little),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .wvalid   (st_wvalid),
    .wready   (st_wready),
    .wdata    (st_wdata)
  );

  fwa_unpacker #(.HALF_W(HALF_W)) u_unpack (
    .clk       (clk),
    .mrst_n    (mrst_n),
    .prst_n    (prst_n),
    .narrow    (cfg_q.rd_narrow),
    .little    (cfg_q.little),
    .rvalid    (st_rvalid),
    .rready    (st_rready),
    .rdata     (st_rdata),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  p_out_follows_store_r10: assert property (@(posedge clk) disable iff (!mrst_n)
    out_valid == st_rvalid);

  p_pop_needs_ready_r10: assert property (@(posedge clk) disable iff (!mrst_n)
    st_rready |-> out_ready);

  p_commit_needs_input_r10: assert property (@(posedge clk) disable iff (!mrst_n)
    st_wvalid |-> in_valid);

endmodule

// File: tb/fifo_width_adapter_tb.sv
module fifo_width_adapter_tb;

  logic        clk = 1'b0;
  logic        mrst_n, prst_n;
  logic        cfg_wr_narrow, cfg_rd_narrow, cfg_little;
  logic        in_valid, in_ready;
  logic [17:0] in_data;
  logic        st_wvalid, st_wready;
  logic [17:0] st_wdata;
  logic        st_rvalid, st_rready;
  logic [17:0] st_rdata;
  logic        out_valid, out_ready;
  logic [17:0] out_data;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic       m_wn, m_rn, m_le;
  logic       b_half;
  logic [8:0] b_held;
  logic       b_phase;

  always #5 clk = ~clk;

  fifo_width_adapter u_dut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .cfg_wr_narrow(cfg_wr_narrow), .cfg_rd_narrow(cfg_rd_narrow), .cfg_little(cfg_little),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .st_wvalid(st_wvalid), .st_wready(st_wready), .st_wdata(st_wdata),
    .st_rvalid(st_rvalid), .st_rready(st_rready), .st_rdata(st_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] join_pair(input logic le, input logic [8:0] first,
                                            input logic [8:0] second);
    return le ? {second, first} : {first, second};
  endfunction

  function automatic logic [8:0] pick_half(input logic le, input logic second,
                                           input logic [17:0] w);
    return (le ^ second) ? w[8:0] : w[17:9];
  endfunction

  task automatic master_reset(input logic wn, input logic rn, input logic le);
    @(negedge clk);
    mrst_n = 1'b0; prst_n = 1'b1;
    cfg_wr_narrow = wn; cfg_rd_narrow = rn; cfg_little = le;
    in_valid = 1'b0; st_wready = 1'b0; st_rvalid = 1'b0; out_ready = 1'b0;
    in_data = '0; st_rdata = '0;
    repeat (3) @(negedge clk);
    mrst_n = 1'b1;
    m_wn = wn; m_rn = rn; m_le = le;
    b_half = 1'b0; b_held = '0; b_phase = 1'b0;
  endtask

  // one cycle: inputs set at negedge, outputs judged 4 ns later, model advanced
  task automatic step_check();
    logic       e_in_ready, e_wvalid, e_rready;
    logic [17:0] e_wdata, e_out;
    #4;
    if (!m_wn) begin
      e_wvalid = in_valid; e_in_ready = st_wready; e_wdata = in_data;
    end else begin
      e_wvalid = in_valid && b_half;
      e_in_ready = b_half ? st_wready : 1'b1;
      e_wdata = join_pair(m_le, b_held, in_data[8:0]);
    end
    if (!m_rn) begin
      e_rready = out_ready; e_out = st_rdata;
    end else begin
      e_rready = out_ready && b_phase;
      e_out = {9'b0, pick_half(m_le, b_phase, st_rdata)};
    end
    chk("R7 in_ready", 18'(in_ready), 18'(e_in_ready));
    chk("R1 st_wvalid", 18'(st_wvalid), 18'(e_wvalid));
    if (e_wvalid) chk("R3/R4 st_wdata", st_wdata, e_wdata);
    chk("R8 st_rready", 18'(st_rready), 18'(e_rready));
    chk("R10 out_valid", 18'(out_valid), 18'(st_rvalid));
    if (st_rvalid) chk("R2/R3/R5 out_data", out_data, e_out);
    if (m_wn && in_valid && e_in_ready) begin
      if (!b_half) b_held = in_data[8:0];
      b_half = !b_half;
    end
    if (m_rn && st_rvalid && out_ready) b_phase = !b_phase;
    @(negedge clk);
  endtask

  task automatic run_random(input int n);
    logic rv = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_valid  = 1'($urandom % 2);
      in_data   = 18'($urandom);
      st_wready = 1'($urandom % 2);
      out_ready = 1'($urandom % 2);
      if (!rv) begin
        rv = 1'($urandom % 2);
        if (rv) st_rdata = 18'($urandom);
      end
      st_rvalid = rv;
      // R6: pins wander after master reset; model keeps latched values
      cfg_wr_narrow = 1'($urandom % 2);
      cfg_rd_narrow = 1'($urandom % 2);
      cfg_little    = 1'($urandom % 2);
      if (rv && out_ready && (!m_rn || b_phase)) rv = 1'b0;
      step_check();
    end
    in_valid = 1'b0; st_rvalid = 1'b0; out_ready = 1'b0; st_wready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    mrst_n = 1'b0; prst_n = 1'b1;

    // reset state: narrow both, nothing pending
    master_reset(1'b1, 1'b1, 1'b0);
    #4;
    chk("R7 reset in_ready", 18'(in_ready), 18'd1);
    chk("R7 reset st_wvalid", 18'(st_wvalid), 18'd0);
    chk("R8 reset st_rready", 18'(st_rready), 18'd0);
    @(negedge clk);

    // R9: partial reset between write halves and between read halves, little-endian
    master_reset(1'b1, 1'b1, 1'b1);
    in_valid = 1'b1; in_data = 18'h3_F0AA; st_wready = 1'b1;
    st_rvalid = 1'b1; st_rdata = 18'h2_A955; out_ready = 1'b1;
    step_check();
    in_valid = 1'b0; out_ready = 1'b0; prst_n = 1'b0;
    @(negedge clk);
    prst_n = 1'b1; b_half = 1'b0; b_phase = 1'b0;
    in_valid = 1'b1; in_data = 18'h0_0123;
    #4;
    chk("R9 lone half after partial reset", 18'(st_wvalid), 18'd0);
    chk("R9 read back to first half", out_data, {9'b0, st_rdata[8:0]});
    @(negedge clk);
    b_half = 1'b1; b_held = 9'h123;
    in_data = 18'h0_0045;
    #4;
    chk("R9 joined word keeps little order", st_wdata, {9'h045, 9'h123});
    @(negedge clk);
    b_half = 1'b0;
    in_valid = 1'b0; st_rvalid = 1'b0;

    // R6 directed: pins flipped after reset leave wide pass-through intact
    master_reset(1'b0, 1'b0, 1'b0);
    cfg_wr_narrow = 1'b1; cfg_rd_narrow = 1'b1; cfg_little = 1'b1;
    in_valid = 1'b1; in_data = 18'h2_BEEF; st_wready = 1'b1;
    st_rvalid = 1'b1; st_rdata = 18'h1_C0DE; out_ready = 1'b0;
    #4;
    chk("R6 wide write kept", st_wdata, 18'h2_BEEF);
    chk("R6 wide write valid kept", 18'(st_wvalid), 18'd1);
    chk("R6 wide read kept", out_data, 18'h1_C0DE);
    @(negedge clk);

    // random traffic under all eight configurations
    for (int c = 0; c < 8; c++) begin
      master_reset(c[0], c[1], c[2]);
      run_random(500);
    end

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule